// File: doc/BRIEF.md
# AHB-Lite Burst Transfer Sequencer

This block is the address-side engine of a single bus master on an AHB-Lite bus. A local client hands it one command at a time: a start address, a burst code, a transfer size, a direction and (for bursts of unspecified length) a beat count. The sequencer then drives the address-phase signals beat by beat. It follows the pipelined address/data phase timing of the bus. It stalls while HREADY is low. It inserts BUSY cycles when the local data side is not ready for the next beat.

Wrapping bursts stay inside a block whose size is the beat count times the transfer size. A non-wrapping command whose bytes would run past a 1 KB address boundary is refused when it is accepted, and no transfer is issued for it. A two-cycle ERROR response on any beat except the final one stops the rest of that burst: the sequencer drives IDLE in the second response cycle. Each burst ends with a one-cycle completion pulse that carries an error flag. When the next command is already waiting at the final beat, it starts on the following cycle with no idle gap.

Top module: `ahbl_burst_seq`

## Requirements
- R1: While reset is held and after its release, htrans is IDLE (2'b00) and doneValid is low; with no burst in progress, cmdReady equals hready.
- R2: The first beat of each accepted command is driven as NONSEQ (2'b10), and every later beat of the same burst as SEQ (2'b11).
- R3: In a non-wrapping burst, each beat address is the previous beat address plus 2^hsize bytes.
- R4: In a wrapping burst (hburst codes 3'b010, 3'b100, 3'b110), beat addresses advance by 2^hsize and wrap inside the aligned block of beats x 2^hsize bytes that holds the start address.
- R5: The number of beats follows the hburst code: 3'b000 one beat; 3'b001 cmdLen+1 beats; 3'b010 and 3'b011 four beats; 3'b100 and 3'b101 eight; 3'b110 and 3'b111 sixteen. After the final beat is accepted, htrans returns to IDLE. If a command is valid at that edge, it is driven instead as NONSEQ on the very next cycle.
- R6: If beatReady is low when a beat is accepted and more beats remain, the next cycle shows BUSY (2'b01) with haddr already at the next beat's address. The BUSY cycle opens no data phase, and the beat is then issued as SEQ after beatReady returns high.
- R7: While hready is low, haddr, hburst, hsize, hwrite and htrans hold their values. The only exception is the error cancellation in R9.
- R8: hburst, hsize and hwrite are taken from the command and stay constant over every beat of the burst.
- R9: If a non-final beat's data phase gets hresp ERROR (2'b01) with hready low, htrans is IDLE in the next cycle. In the second response cycle (hready high, hresp ERROR), doneValid and doneErr are both high.
- R10: A non-wrapping command with (cmdAddr mod 1024) + beats x 2^cmdSize > 1024 raises cmdRejected in its accept cycle, and no transfer is issued for it.
- R11: doneValid is high for one cycle, the cycle in which the final beat's data phase completes. doneErr is low when that response is OKAY (2'b00).
- R12: hprot is a constant set by a parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Command taken this cycle |
| cmdAddr | input | AW | Start address |
| cmdBurst | input | 3 | Burst code |
| cmdSize | input | 3 | Transfer size, log2 of bytes |
| cmdWrite | input | 1 | Direction, 1 = write |
| cmdLen | input | LEN_W | Beats minus one for unspecified-length bursts |
| cmdRejected | output | 1 | Accepted command refused for crossing 1 KB |
| beatReady | input | 1 | Local data side can take the next beat |
| beatDone | output | 1 | A beat's data phase completes this cycle |
| doneValid | output | 1 | Burst finished this cycle |
| doneErr | output | 1 | The finished burst ended with ERROR |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Transfer type |
| hburst | output | 3 | Burst code on the bus |
| hsize | output | 3 | Transfer size on the bus |
| hwrite | output | 1 | Direction on the bus |
| hprot | output | 4 | Fixed protection code |
| hready | input | 1 | Bus ready |
| hresp | input | 2 | Slave response |

## Verification
The assertions assume that the slave follows the bus rules. It answers an ERROR as two cycles, with hready low in the first cycle and high in the second. It never answers the ERROR with hready low when no data phase is open. They also assume that cmdSize does not exceed the width of the data bus, so that a wrap block never reaches 1 KB. The stimulus keeps to these rules: every ERROR is driven as that exact two-cycle pair during a SEQ beat's data phase, every size is at most a word, and all other responses are OKAY.

// File: rtl/ahbl_seq_pkg.sv
package ahbl_seq_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [2:0] BU_SINGLE = 3'b000;
  localparam logic [2:0] BU_INCR   = 3'b001;

  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] RESP_ERROR = 2'b01;

  // Strobes from the control FSM to the address datapath
  typedef struct packed {
    logic load;   // capture a new command
    logic step;   // move to the next beat
  } dp_strobe_t;

  // Wrapping codes are the even ones above SINGLE
  function automatic logic isWrap(input logic [2:0] code);
    return (code != BU_SINGLE) && !code[0];
  endfunction

endpackage

// File: rtl/ahbl_seq_addr.sv
module ahbl_seq_addr
  import ahbl_seq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LEN_W      = 8,
  parameter int BOUND_BITS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       strobe,
  input  logic [AW-1:0]    cmdAddr,
  input  logic [2:0]       cmdBurst,
  input  logic [2:0]       cmdSize,
  input  logic             cmdWrite,
  input  logic [LEN_W-1:0] cmdLen,
  output logic [AW-1:0]    haddr,
  output logic [2:0]       hburst,
  output logic [2:0]       hsize,
  output logic             hwrite,
  output logic             lastBeat,
  output logic             crossErr
);

  localparam int CNT_W     = LEN_W + 1;
  localparam int CROSS_W   = CNT_W + 9;
  localparam int BOUND_LEN = 1 << BOUND_BITS;

  logic [AW-1:0]    addrQ;
  logic [2:0]       burstQ;
  logic [2:0]       sizeQ;
  logic             writeQ;
  logic [CNT_W-1:0] leftQ;

  logic [CNT_W-1:0]   cmdBeats;
  logic [CROSS_W-1:0] cmdBytes;
  logic [CROSS_W-1:0] cmdEnd;
  logic [AW-1:0]      stepBytes;
  logic [AW-1:0]      wrapMask;
  logic [AW-1:0]      nextAddr;

  function automatic logic [CNT_W-1:0] beatsOf(input logic [2:0] code,
                                               input logic [LEN_W-1:0] len);
    case (code)
      3'b000:          return CNT_W'(1);
      3'b001:          return CNT_W'(len) + CNT_W'(1);
      3'b010, 3'b011:  return CNT_W'(4);
      3'b100, 3'b101:  return CNT_W'(8);
      default:         return CNT_W'(16);
    endcase
  endfunction

  // Boundary check on the incoming command
  always_comb begin
    cmdBeats = beatsOf(cmdBurst, cmdLen);
    cmdBytes = CROSS_W'(cmdBeats) << cmdSize;
    cmdEnd   = CROSS_W'(cmdAddr[BOUND_BITS-1:0]) + cmdBytes;
    crossErr = !isWrap(cmdBurst) && (cmdEnd > CROSS_W'(BOUND_LEN));
  end

  // Next beat address from the held burst
  always_comb begin
    stepBytes = AW'(1) << sizeQ;
    wrapMask  = (AW'(beatsOf(burstQ, '0)) << sizeQ) - AW'(1);
    if (isWrap(burstQ))
      nextAddr = (addrQ & ~wrapMask) | ((addrQ + stepBytes) & wrapMask);
    else
      nextAddr = addrQ + stepBytes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      burstQ <= BU_SINGLE;
      sizeQ  <= '0;
      writeQ <= 1'b0;
      leftQ  <= CNT_W'(1);
    end else if (strobe.load) begin
      addrQ  <= cmdAddr;
      burstQ <= cmdBurst;
      sizeQ  <= cmdSize;
      writeQ <= cmdWrite;
      leftQ  <= cmdBeats;
    end else if (strobe.step) begin
      addrQ  <= nextAddr;
      leftQ  <= leftQ - CNT_W'(1);
    end
  end

  assign haddr    = addrQ;
  assign hburst   = burstQ;
  assign hsize    = sizeQ;
  assign hwrite   = writeQ;
  assign lastBeat = (leftQ == CNT_W'(1));

  // R4: a step inside a wrapping burst never leaves the wrap block
  p_wrap_block_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && isWrap(burstQ)) |=>
      ((addrQ & ~wrapMask) == ($past(addrQ) & ~$past(wrapMask))));

endmodule

// File: rtl/ahbl_seq_ctrl.sv
module ahbl_seq_ctrl
  import ahbl_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       crossErr,
  input  logic       lastBeat,
  input  logic       beatReady,
  input  logic       hready,
  input  logic [1:0] hresp,
  output logic [1:0] htrans,
  output logic       cmdReady,
  output logic       cmdRejected,
  output logic       beatDone,
  output logic       doneValid,
  output logic       doneErr,
  output dp_strobe_t strobe
);

  trans_e transQ, transD;
  logic   dataPhaseQ;   // a beat's data phase is open
  logic   dataLastQ;    // that beat is the final one of its burst

  logic xferNow, cmdFire, cmdStart, errFirst, cancel;

  always_comb begin
    xferNow     = transQ[1];
    cmdReady    = hready && ((transQ == TR_IDLE) || (xferNow && lastBeat));
    cmdFire     = cmdValid && cmdReady;
    cmdRejected = cmdFire && crossErr;
    cmdStart    = cmdFire && !crossErr;
    errFirst    = dataPhaseQ && !hready && (hresp == RESP_ERROR);
    cancel      = errFirst && !dataLastQ && (transQ != TR_IDLE);

    strobe.load = cmdStart;
    strobe.step = hready && xferNow && !lastBeat;

    transD = transQ;
    if (cancel)
      transD = TR_IDLE;
    else if (hready) begin
      if (cmdStart)
        transD = TR_NONSEQ;
      else if ((transQ == TR_IDLE) || (xferNow && lastBeat))
        transD = TR_IDLE;
      else
        transD = beatReady ? TR_SEQ : TR_BUSY;
    end

    beatDone  = dataPhaseQ && hready;
    doneValid = beatDone && (dataLastQ || (hresp == RESP_ERROR));
    doneErr   = doneValid && (hresp == RESP_ERROR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      transQ     <= TR_IDLE;
      dataPhaseQ <= 1'b0;
      dataLastQ  <= 1'b0;
    end else begin
      transQ <= transD;
      if (hready) begin
        dataPhaseQ <= xferNow;
        dataLastQ  <= xferNow && lastBeat;
      end
    end
  end

  assign htrans = transQ;

  // R2: a NONSEQ with beats left is followed by SEQ or BUSY
  p_seq_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hready && transQ == TR_NONSEQ && !lastBeat) |=>
      (transQ == TR_SEQ || transQ == TR_BUSY));

  // R6: local side not ready mid-burst gives BUSY
  p_busy_midburst_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hready && transQ[1] && !lastBeat && !beatReady) |=> (transQ == TR_BUSY));

  // R9: first ERROR cycle of a non-final beat cancels the burst
  p_cancel_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dataPhaseQ && !hready && hresp == RESP_ERROR && !dataLastQ) |=>
      (transQ == TR_IDLE));

  // R10: a refused command issues nothing
  p_reject_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdRejected |=> (transQ == TR_IDLE));

endmodule

// File: rtl/ahbl_burst_seq.sv
module ahbl_burst_seq
  import ahbl_seq_pkg::*;
#(
  parameter int         AW         = 32,
  parameter int         LEN_W      = 8,
  parameter int         BOUND_BITS = 10,
  parameter logic [3:0] HPROT_VAL  = 4'b0011
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [AW-1:0]    cmdAddr,
  input  logic [2:0]       cmdBurst,
  input  logic [2:0]       cmdSize,
  input  logic             cmdWrite,
  input  logic [LEN_W-1:0] cmdLen,
  output logic             cmdRejected,
  input  logic             beatReady,
  output logic             beatDone,
  output logic             doneValid,
  output logic             doneErr,
  output logic [AW-1:0]    haddr,
  output logic [1:0]       htrans,
  output logic [2:0]       hburst,
  output logic [2:0]       hsize,
  output logic             hwrite,
  output logic [3:0]       hprot,
  input  logic             hready,
  input  logic [1:0]       hresp
);

  dp_strobe_t strobe;
  logic       lastBeat;
  logic       crossErr;

  ahbl_seq_addr #(
    .AW(AW), .LEN_W(LEN_W), .BOUND_BITS(BOUND_BITS)
  ) u_addr (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdAddr(cmdAddr), .cmdBurst(cmdBurst), .cmdSize(cmdSize),
    .cmdWrite(cmdWrite), .cmdLen(cmdLen),
    .haddr(haddr), .hburst(hburst), .hsize(hsize), .hwrite(hwrite),
    .lastBeat(lastBeat), .crossErr(crossErr)
  );

  ahbl_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .crossErr(crossErr),
    .lastBeat(lastBeat), .beatReady(beatReady), .hready(hready),
    .hresp(hresp), .htrans(htrans), .cmdReady(cmdReady),
    .cmdRejected(cmdRejected), .beatDone(beatDone),
    .doneValid(doneValid), .doneErr(doneErr), .strobe(strobe)
  );

  assign hprot = HPROT_VAL;

  // R7: address-phase outputs hold across a wait state
  p_hold_wait_r7: assert property (@(posedge clk) disable iff (!rstN)
    !hready |=> ($stable(haddr) && $stable(hburst) && $stable(hsize) && $stable(hwrite)));

  // R3: incrementing bursts step by the transfer size
  p_incr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hready && htrans[1] && !lastBeat && !isWrap(hburst)) |=>
      (haddr == $past(haddr) + (AW'(1) << $past(hsize))));

  // R8: control fields constant inside a burst
  p_ctrl_const_r8: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == TR_SEQ || htrans == TR_BUSY) |->
      ($stable(hburst) && $stable(hsize) && $stable(hwrite)));

endmodule

// File: tb/ahbl_burst_seq_bench.sv
module ahbl_burst_seq_bench;

  localparam int PERIOD = 10;
  localparam int NV     = 10;

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  burst;
    logic [2:0]  size;
    logic [7:0]  len;
    logic [8:0]  beats;
    logic        rej;
  } vec_t;

  // start, burst code, size, len, expected beats, expected reject
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0100, 3'b000, 3'd2, 8'd0, 9'd1,  1'b0},
    '{32'h0000_0020, 3'b011, 3'd2, 8'd0, 9'd4,  1'b0},
    '{32'h0000_0034, 3'b010, 3'd2, 8'd0, 9'd4,  1'b0},
    '{32'h0000_0016, 3'b100, 3'd1, 8'd0, 9'd8,  1'b0},
    '{32'h0000_03F0, 3'b101, 3'd2, 8'd0, 9'd8,  1'b1},
    '{32'h0000_03FC, 3'b001, 3'd0, 8'd3, 9'd4,  1'b0},
    '{32'h0000_03C4, 3'b110, 3'd2, 8'd0, 9'd16, 1'b0},
    '{32'h0000_03C0, 3'b111, 3'd2, 8'd0, 9'd16, 1'b0},
    '{32'h0000_0600, 3'b001, 3'd2, 8'd0, 9'd1,  1'b0},
    '{32'h0000_07F4, 3'b011, 3'd2, 8'd0, 9'd4,  1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [31:0] cmdAddr = '0;
  logic [2:0]  cmdBurst = '0;
  logic [2:0]  cmdSize = '0;
  logic        cmdWrite = 1'b0;
  logic [7:0]  cmdLen = '0;
  logic        cmdRejected;
  logic        beatReady = 1'b1;
  logic        beatDone, doneValid, doneErr;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic [2:0]  hburst, hsize;
  logic        hwrite;
  logic [3:0]  hprot;
  logic        hready = 1'b1;
  logic [1:0]  hresp = 2'b00;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  ahbl_burst_seq u_ahbl_burst_seq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdBurst(cmdBurst), .cmdSize(cmdSize),
    .cmdWrite(cmdWrite), .cmdLen(cmdLen), .cmdRejected(cmdRejected),
    .beatReady(beatReady), .beatDone(beatDone), .doneValid(doneValid),
    .doneErr(doneErr), .haddr(haddr), .htrans(htrans), .hburst(hburst),
    .hsize(hsize), .hwrite(hwrite), .hprot(hprot), .hready(hready),
    .hresp(hresp)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setCmd(input logic [31:0] a, input logic [2:0] b,
                        input logic [2:0] s, input logic w, input logic [7:0] l);
    cmdValid = 1'b1; cmdAddr = a; cmdBurst = b; cmdSize = s;
    cmdWrite = w; cmdLen = l;
  endtask

  function automatic logic [31:0] expAddr(input vec_t v, input int i);
    longint bytes = longint'(1) << v.size;
    longint block = longint'(v.beats) * bytes;
    longint base;
    if (v.burst == 3'b010 || v.burst == 3'b100 || v.burst == 3'b110) begin
      base = longint'(v.addr) - (longint'(v.addr) % block);
      return 32'(base + ((longint'(v.addr) - base + i * bytes) % block));
    end
    return 32'(longint'(v.addr) + i * bytes);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // ---------------- reset (R1, R12)
    repeat (3) @(negedge clk);
    chk("R1", "htrans in reset", 32'(htrans), 32'h0);
    chk("R1", "doneValid in reset", 32'(doneValid), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "htrans after reset", 32'(htrans), 32'h0);
    chk("R1", "cmdReady when idle", 32'(cmdReady), 32'h1);
    chk("R12", "hprot fixed", 32'(hprot), 32'h3);

    // ---------------- vector walk (R2 R3 R4 R5 R8 R10 R11)
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      setCmd(v.addr, v.burst, v.size, k[0], v.len);
      #1;
      chk("R10", "reject flag", 32'(cmdRejected), 32'(v.rej));
      @(negedge clk);
      cmdValid = 1'b0;
      if (v.rej) begin
        chk("R10", "no transfer after reject", 32'(htrans), 32'h0);
        @(negedge clk);
        chk("R10", "still idle after reject", 32'(htrans), 32'h0);
      end else begin
        for (int i = 0; i < int'(v.beats); i++) begin
          chk("R2", "beat type", 32'(htrans), (i == 0) ? 32'h2 : 32'h3);
          if (v.burst[0] || v.burst == 3'b000)
            chk("R3", "incr address", haddr, expAddr(v, i));
          else
            chk("R4", "wrap address", haddr, expAddr(v, i));
          chk("R8", "controls held", {25'd0, hburst, hsize, hwrite},
              {25'd0, v.burst, v.size, k[0]});
          @(negedge clk);
        end
        chk("R5", "idle after final beat", 32'(htrans), 32'h0);
        chk("R11", "done on final data phase", {30'd0, doneValid, doneErr}, 32'h2);
        @(negedge clk);
        chk("R11", "done is one cycle", 32'(doneValid), 32'h0);
      end
    end

    // ---------------- BUSY insertion (R6)
    setCmd(32'h40, 3'b011, 3'd2, 1'b0, 8'd0);
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R2", "busy test first beat", 32'(htrans), 32'h2);
    beatReady = 1'b0;
    @(negedge clk);
    chk("R6", "busy type", 32'(htrans), 32'h1);
    chk("R6", "busy carries next address", haddr, 32'h44);
    chk("R6", "first data phase completes", 32'(beatDone), 32'h1);
    @(negedge clk);
    chk("R6", "busy held", 32'(htrans), 32'h1);
    chk("R6", "busy opens no data phase", 32'(beatDone), 32'h0);
    beatReady = 1'b1;
    @(negedge clk);
    chk("R6", "seq after busy", 32'(htrans), 32'h3);
    chk("R6", "seq address after busy", haddr, 32'h44);
    repeat (2) @(negedge clk);
    chk("R3", "last busy-test address", haddr, 32'h4C);
    @(negedge clk);
    chk("R11", "busy burst done", 32'(doneValid), 32'h1);
    @(negedge clk);

    // ---------------- wait states (R7)
    setCmd(32'h80, 3'b011, 3'd2, 1'b1, 8'd0);
    @(negedge clk);
    cmdValid = 1'b0;
    @(negedge clk);
    hready = 1'b0;
    #1;
    chk("R7", "no beat completes in wait", 32'(beatDone), 32'h0);
    @(negedge clk);
    chk("R7", "htrans held in wait", 32'(htrans), 32'h3);
    chk("R7", "haddr held in wait", haddr, 32'h84);
    @(negedge clk);
    chk("R7", "haddr held second wait", haddr, 32'h84);
    hready = 1'b1;
    @(negedge clk);
    chk("R7", "advance after wait", haddr, 32'h88);
    repeat (2) @(negedge clk);
    chk("R5", "idle after waited burst", 32'(htrans), 32'h0);
    @(negedge clk);

    // ---------------- back-to-back (R5)
    setCmd(32'h200, 3'b000, 3'd2, 1'b0, 8'd0);
    @(negedge clk);
    chk("R2", "single is nonseq", 32'(htrans), 32'h2);
    setCmd(32'h300, 3'b011, 3'd2, 1'b1, 8'd0);
    #1;
    chk("R5", "ready at final beat", 32'(cmdReady), 32'h1);
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R5", "back-to-back nonseq", 32'(htrans), 32'h2);
    chk("R5", "back-to-back address", haddr, 32'h300);
    chk("R11", "first burst done during second", 32'(doneValid), 32'h1);
    repeat (4) @(negedge clk);
    chk("R5", "idle after second burst", 32'(htrans), 32'h0);
    @(negedge clk);

    // ---------------- ERROR cancel (R9)
    setCmd(32'h500, 3'b101, 3'd2, 1'b0, 8'd0);
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "address before error", haddr, 32'h508);
    hready = 1'b0; hresp = 2'b01;
    #1;
    chk("R9", "no done in first error cycle", 32'(doneValid), 32'h0);
    @(negedge clk);
    chk("R9", "idle after first error cycle", 32'(htrans), 32'h0);
    hready = 1'b1;
    #1;
    chk("R9", "done with error", {30'd0, doneValid, doneErr}, 32'h3);
    @(negedge clk);
    hresp = 2'b00;
    chk("R9", "burst stays cancelled", 32'(htrans), 32'h0);
    chk("R9", "no further data phase", 32'(beatDone), 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule